// File: doc/BRIEF.md
# Power Management Wake Event Generator

This block decides when a host-controller function with PCI-style power management should raise its wake status and pull its wake request line. It holds the function's power state (D0 uninitialized, D0 active, D1, D2, D3). It watches a vector of per-source interrupt status bits, a matching mask vector and a global interrupt enable. When any source is both pending and unmasked while the function sits in D0, the wake status bit is set.

A configuration bit picks one of two meanings of "unmasked". In the default meaning, the global enable must also be 1. In the alternative meaning, the global enable is left out of the decision. This avoids a wake request and an ordinary interrupt firing together as the function returns to full power. An identification register reports the chosen meaning in its low bit. A card-presence input, synchronized and edge-detected, can also set the status when wake requests are enabled, in any power state. The wake line is open-drain, so it is modelled as a drive-low enable.

Software reaches the block through a small word-wide register port. The read data is combinational from the address, and writes take effect at the clock edge. The status bit is cleared by writing a one to it.

Top module: `pm_wake_gen`

## Requirements
- R1: After reset, the power state reads 00 (D0), the D0-active flag, wake enable, wake status and the ignore-global-enable bit all read 0, and `pme_oe` is 0.
- R2: Register 0 bits [1:0] hold the power state, encoded 00 = D0, 01 = D1, 10 = D2, 11 = D3. A write stores it and a read returns it. Bit 8 of register 0 is the wake enable and is read/write.
- R3: Bit 16 of register 0 is read-only. It is 0 after reset, becomes 1 on the first write of power state 00 (writes of other states leave it 0), and then stays 1 until reset.
- R4: With register 1 bit 0 clear, while the power state is 00, the wake status (register 0 bit 15) is set one clock after any index n has `ev_status[n]`, `ev_mask[n]` and `master_ie` all 1.
- R5: With register 1 bit 0 set, while the power state is 00, the wake status is set one clock after any index n has `ev_status[n]` and `ev_mask[n]` both 1, whatever `master_ie` is.
- R6: In power states 01, 10 and 11, interrupt events do not set the wake status.
- R7: Register 2 reads the parameter `ID_CODE` with bit 0 replaced by the current value of register 1 bit 0. Register 3 reads 0.
- R8: A 0-to-1 transition of `card_present`, seen after the synchronizer, sets the wake status in any power state when the wake enable is 1. A level held at 1 does not set it again, and a transition while the wake enable is 0 has no effect.
- R9: Writing register 0 with bit 15 = 1 clears the wake status. Writing bit 15 = 0 leaves it unchanged. If a set and a clear happen in the same cycle, the set wins.
- R10: `pme_oe` is 1 exactly when both the wake status and the wake enable are 1, so it drops when either is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ev_status | input | N_EV | Per-source pending interrupt bits |
| ev_mask | input | N_EV | Per-source interrupt mask (1 = enabled) |
| master_ie | input | 1 | Global interrupt enable |
| card_present | input | 1 | Asynchronous card presence level |
| pme_oe | output | 1 | Drive-low enable for the open-drain wake line |

## Verification
The bench sweeps every pairing of status and mask vectors, both values of the global enable and both settings of the ignore bit, in all four power states. A design that always or never gates with the global enable, or that lets events wake from D1 to D3, therefore shows a mismatch on the status bit. Card insertion is exercised with a held level after clearing the status, which catches a level-sensitive detector that re-sets the status forever, and with wake disabled, which catches a missing enable gate. It also checks the D0-active flag across non-D0 writes, which catches a flag set by any write. It drives the wake enable low while the status is still set, which catches an output wired to the status alone.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
   typedef enum logic [1:0] {
      PS_D0 = 2'b00,
      PS_D1 = 2'b01,
      PS_D2 = 2'b10,
      PS_D3 = 2'b11
   } pstate_e;

   localparam int REG_AW = 2;
   localparam int DW     = 32;

   localparam logic [REG_AW-1:0] A_PMCS = 2'd0;
   localparam logic [REG_AW-1:0] A_CFG  = 2'd1;
   localparam logic [REG_AW-1:0] A_ID   = 2'd2;

   localparam int B_EN  = 8;
   localparam int B_STS = 15;
   localparam int B_ACT = 16;
   localparam int B_IGN = 0;
endpackage

// File: rtl/pmw_sync_edge.sv
module pmw_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("pmw_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], async_in};
         last  <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/pmw_event_qual.sv
module pmw_event_qual #(
   parameter int N_EV = 4
) (
   input  logic [N_EV-1:0] ev_status,
   input  logic [N_EV-1:0] ev_mask,
   input  logic            master_ie,
   input  logic            ign_master,
   output logic            hit
);
   generate
      if (N_EV < 1 || N_EV > 32) begin : g_bad
         $error("pmw_event_qual: N_EV must be in 1..32");
      end
   endgenerate

   logic [N_EV-1:0] armed;

   for (genvar i = 0; i < N_EV; i++) begin : g_bit
      assign armed[i] = ev_status[i] & ev_mask[i];
   end

   assign hit = (|armed) & (master_ie | ign_master);
endmodule

// File: rtl/pmw_regs.sv
module pmw_regs
   import pmw_pkg::*;
#(
   parameter logic [DW-1:0] ID_CODE = 32'h5A3C_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] addr,
   input  logic              wr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   input  logic              ev_hit,
   input  logic              card_rise,
   output pstate_e           pstate,
   output logic              wake_en,
   output logic              wake_sts,
   output logic              d0_active,
   output logic              ign_master
);
   logic wr_pmcs, wr_cfg, set_sts, clr_sts;
   logic unused_wdata;

   assign unused_wdata = ^wdata;
   assign wr_pmcs = wr && (addr == A_PMCS);
   assign wr_cfg  = wr && (addr == A_CFG);
   assign set_sts = ((pstate == PS_D0) && ev_hit) || (wake_en && card_rise);
   assign clr_sts = wr_pmcs && wdata[B_STS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pstate     <= PS_D0;
         wake_en    <= 1'b0;
         d0_active  <= 1'b0;
         ign_master <= 1'b0;
      end else begin
         if (wr_pmcs) begin
            pstate  <= pstate_e'(wdata[1:0]);
            wake_en <= wdata[B_EN];
            if (wdata[1:0] == PS_D0) d0_active <= 1'b1;
         end
         if (wr_cfg) ign_master <= wdata[B_IGN];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wake_sts <= 1'b0;
      else if (set_sts) wake_sts <= 1'b1;
      else if (clr_sts) wake_sts <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_PMCS: begin
            rdata[1:0]   = pstate;
            rdata[B_EN]  = wake_en;
            rdata[B_STS] = wake_sts;
            rdata[B_ACT] = d0_active;
         end
         A_CFG:   rdata[B_IGN] = ign_master;
         A_ID:    rdata = {ID_CODE[DW-1:1], ign_master};
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/pm_wake_gen.sv
module pm_wake_gen
   import pmw_pkg::*;
#(
   parameter int              N_EV        = 4,
   parameter int              SYNC_STAGES = 2,
   parameter logic [DW-1:0]   ID_CODE     = 32'h5A3C_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   input  logic [N_EV-1:0]   ev_status,
   input  logic [N_EV-1:0]   ev_mask,
   input  logic              master_ie,
   input  logic              card_present,
   output logic              pme_oe
);
   logic    ev_hit, card_rise;
   pstate_e pstate;
   logic    wake_en, wake_sts, d0_active, ign_master;

   pmw_event_qual #(.N_EV(N_EV)) u_qual (
      .ev_status (ev_status),
      .ev_mask   (ev_mask),
      .master_ie (master_ie),
      .ign_master(ign_master),
      .hit       (ev_hit)
   );

   pmw_sync_edge #(.STAGES(SYNC_STAGES)) u_card (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(card_present),
      .rise    (card_rise)
   );

   pmw_regs #(.ID_CODE(ID_CODE)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (reg_addr),
      .wr        (reg_wr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .ev_hit    (ev_hit),
      .card_rise (card_rise),
      .pstate    (pstate),
      .wake_en   (wake_en),
      .wake_sts  (wake_sts),
      .d0_active (d0_active),
      .ign_master(ign_master)
   );

   assign pme_oe = wake_sts & wake_en;
endmodule

// File: rtl/pmw_checker.sv
module pmw_checker #(
   parameter int N_EV = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      reg_addr,
   input logic            reg_wr,
   input logic            wd_en,
   input logic            wd_clr,
   input logic            rd_id0,
   input logic [N_EV-1:0] ev_status,
   input logic [N_EV-1:0] ev_mask,
   input logic            master_ie,
   input logic            pme_oe,
   input logic [1:0]      pstate,
   input logic            wake_en,
   input logic            wake_sts,
   input logic            d0_active,
   input logic            ign_master,
   input logic            card_rise
);
   logic ev_cause, any_cause, pmcs_wr;
   assign ev_cause  = (pstate == 2'b00) && (|(ev_status & ev_mask)) && (master_ie || ign_master);
   assign any_cause = ev_cause || (wake_en && card_rise);
   assign pmcs_wr   = reg_wr && (reg_addr == 2'd0);

   AST_D0_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_cause |=> wake_sts); // R4
   AST_STS_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_sts) |-> $past(any_cause)); // R6
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (pmcs_wr && wd_clr && !any_cause) |=> !wake_sts); // R9
   AST_ID_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd2) |-> (rd_id0 == ign_master)); // R7
   AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      d0_active |=> d0_active); // R3
   AST_EN_OFF_DROPS_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (pmcs_wr && !wd_en) |=> !pme_oe); // R10
   AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      card_rise |=> !card_rise); // R8
endmodule

bind pm_wake_gen pmw_checker #(.N_EV(N_EV)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .wd_en     (reg_wdata[8]),
   .wd_clr    (reg_wdata[15]),
   .rd_id0    (reg_rdata[0]),
   .ev_status (ev_status),
   .ev_mask   (ev_mask),
   .master_ie (master_ie),
   .pme_oe    (pme_oe),
   .pstate    (pstate),
   .wake_en   (wake_en),
   .wake_sts  (wake_sts),
   .d0_active (d0_active),
   .ign_master(ign_master),
   .card_rise (card_rise)
);

// File: tb/sim_pm_wake_gen.sv
`timescale 1ns/1ps
module sim_pm_wake_gen;
   localparam int          N = 4;
   localparam logic [31:0] IDC = 32'h5A3C_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [N-1:0]  ev_status = '0;
   logic [N-1:0]  ev_mask = '0;
   logic          master_ie = 1'b0;
   logic          card_present = 1'b0;
   logic          pme_oe;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   pm_wake_gen #(.N_EV(N), .SYNC_STAGES(2), .ID_CODE(IDC)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_status(ev_status),
      .ev_mask(ev_mask), .master_ie(master_ie), .card_present(card_present),
      .pme_oe(pme_oe)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   function automatic logic [31:0] pmcs(input logic [1:0] ps, input bit en, input bit clr);
      logic [31:0] v = '0;
      v[1:0] = ps; v[8] = en; v[15] = clr;
      return v;
   endfunction

   task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] r;
      cycles(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_reg(2'd0, r);
      check(r[1:0] == 2'b00 && !r[8] && !r[15] && !r[16], "R1 pmcs", r, 32'h0);
      rd_reg(2'd1, r);
      check(r[0] == 1'b0, "R1 cfg", r, 32'h0);
      check(pme_oe == 1'b0, "R1 pme_oe", {31'b0, pme_oe}, 32'h0);

      // R2 / R3 power state and active flag
      wr_reg(2'd0, pmcs(2'b01, 0, 0));
      rd_reg(2'd0, r);
      check(r[1:0] == 2'b01, "R2 state D1", r, 32'h1);
      check(r[16] == 1'b0, "R3 no flag on D1", r, 32'h1);
      wr_reg(2'd0, pmcs(2'b10, 1, 0));
      rd_reg(2'd0, r);
      check(r[1:0] == 2'b10 && r[8], "R2 state D2 with enable", r, 32'h102);
      wr_reg(2'd0, pmcs(2'b11, 0, 0));
      rd_reg(2'd0, r);
      check(r[1:0] == 2'b11 && !r[8] && !r[16], "R2 state D3", r, 32'h3);
      wr_reg(2'd0, pmcs(2'b00, 0, 0));
      rd_reg(2'd0, r);
      check(r[1:0] == 2'b00 && r[16], "R3 flag set by D0 write", r, 32'h10000);
      wr_reg(2'd0, pmcs(2'b11, 0, 0));
      rd_reg(2'd0, r);
      check(r[16] == 1'b1, "R3 flag sticky", r, 32'h10003);

      // R7 identification mirror
      rd_reg(2'd2, r);
      check(r == {IDC[31:1], 1'b0}, "R7 id ign=0", r, {IDC[31:1], 1'b0});
      wr_reg(2'd1, 32'h1);
      rd_reg(2'd2, r);
      check(r == {IDC[31:1], 1'b1}, "R7 id ign=1", r, {IDC[31:1], 1'b1});
      rd_reg(2'd3, r);
      check(r == 32'h0, "R7 unused address", r, 32'h0);

      // R4 R5 R6 exhaustive sweep
      for (int ig = 0; ig < 2; ig++) begin
         wr_reg(2'd1, 32'(ig));
         for (int ps = 0; ps < 4; ps++) begin
            for (int mie = 0; mie < 2; mie++) begin
               for (int st = 0; st < (1 << N); st++) begin
                  for (int mk = 0; mk < (1 << N); mk++) begin
                     bit exp_s;
                     @(negedge clk);
                     ev_status = '0; ev_mask = '0;
                     reg_addr = 2'd0; reg_wdata = pmcs(2'(ps), 0, 1); reg_wr = 1'b1;
                     @(negedge clk);
                     reg_wr = 1'b0;
                     ev_status = N'(st); ev_mask = N'(mk); master_ie = 1'(mie);
                     @(negedge clk);
                     rd_reg(2'd0, r);
                     exp_s = (ps == 0) && ((st & mk) != 0) && (mie == 1 || ig == 1);
                     if (ps != 0)
                        check(r[15] == exp_s, "R6 no wake outside D0", r, 32'(exp_s));
                     else if (ig == 1)
                        check(r[15] == exp_s, "R5 ignore global enable", r, 32'(exp_s));
                     else
                        check(r[15] == exp_s, "R4 default gating", r, 32'(exp_s));
                  end
               end
            end
         end
      end
      @(negedge clk);
      ev_status = '0; ev_mask = '0; master_ie = 1'b0;

      // R8 card insertion
      wr_reg(2'd0, pmcs(2'b11, 1, 1));
      card_present = 1'b1;
      cycles(3);
      rd_reg(2'd0, r);
      check(r[15] == 1'b1, "R8 insertion sets status in D3", r, 32'h1);
      check(pme_oe == 1'b1, "R10 oe asserted", {31'b0, pme_oe}, 32'h1);
      wr_reg(2'd0, pmcs(2'b11, 1, 1));
      cycles(5);
      rd_reg(2'd0, r);
      check(r[15] == 1'b0, "R8 steady level no retrigger", r, 32'h0);
      check(pme_oe == 1'b0, "R10 oe drops after clear", {31'b0, pme_oe}, 32'h0);
      card_present = 1'b0;
      cycles(4);
      wr_reg(2'd0, pmcs(2'b01, 0, 0));
      card_present = 1'b1;
      cycles(4);
      rd_reg(2'd0, r);
      check(r[15] == 1'b0, "R8 disabled insertion ignored", r, 32'h0);
      card_present = 1'b0;
      cycles(4);

      // R9 / R10 via D0 event with enable off
      wr_reg(2'd1, 32'h0);
      wr_reg(2'd0, pmcs(2'b00, 0, 1));
      ev_status = 4'b0100; ev_mask = 4'b0100; master_ie = 1'b1;
      @(negedge clk);
      ev_status = '0;
      @(negedge clk);
      check(pme_oe == 1'b0, "R10 oe off while disabled", {31'b0, pme_oe}, 32'h0);
      wr_reg(2'd0, pmcs(2'b00, 1, 0));
      rd_reg(2'd0, r);
      check(r[15] == 1'b1, "R9 write zero keeps status", r, 32'h1);
      check(pme_oe == 1'b1, "R10 oe with enable", {31'b0, pme_oe}, 32'h1);
      wr_reg(2'd0, pmcs(2'b00, 0, 0));
      check(pme_oe == 1'b0, "R10 oe drops on disable", {31'b0, pme_oe}, 32'h0);
      rd_reg(2'd0, r);
      check(r[15] == 1'b1, "R9 status survives disable", r, 32'h1);
      wr_reg(2'd0, pmcs(2'b00, 0, 1));
      rd_reg(2'd0, r);
      check(r[15] == 1'b0, "R9 write one clears", r, 32'h0);

      // R9 set wins over clear in same cycle
      @(negedge clk);
      ev_status = 4'b0001; ev_mask = 4'b0001;
      reg_addr = 2'd0; reg_wdata = pmcs(2'b00, 0, 1); reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; ev_status = '0;
      rd_reg(2'd0, r);
      check(r[15] == 1'b1, "R9 set beats clear", r, 32'h1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule